// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block is the transmit engine of a serial audio port. The port's clock generator supplies a one-cycle `bitTick` strobe once per bit period. At each tick the block presents one new bit on `serData`, drives `frameSync`, and marks the tick as carrying data on `bitClkEn`. Sample words come from a show-ahead transmit FIFO. The FIFO's current word is visible whenever `fifoEmpty` is low, and `fifoPop` consumes it.

The frame layout is set at run time:
- the number of slots in a frame;
- a width for slot 0 and a separate width for the remaining slots (8 to 32 bits each);
- the sync pulse length;
- a per-slot mute mask;
- the bit of the 32-bit word that leaves first.

Three framings are available: I2S-style with a low sync that leads the data by one bit, left-justified, and right-justified with the sync marking the end of the frame. Two sticky status flags report a chosen slot starting and a FIFO underrun. Each flag is cleared by a pulse on its own clear input. Dropping `enable` lets the frame in progress finish, and a synchronous soft reset returns the engine to idle.

Top module: `audio_frame_tx`

## Requirements
- R1: A frame has `cfgSlotsM1`+1 slots. Slot 0 is `cfgHeadBitsM1`+1 bits wide and every other slot is `cfgBitsM1`+1 bits wide. One bit is presented per emitting tick. `bitClkEn` is high exactly after ticks that present a bit, and `serData` is low whenever `bitClkEn` is low.
- R2: Within an unmasked slot, the first bit is `word[cfgFirstBit]`. Each later bit takes the next lower index, wrapping from 0 to 31.
- R3: When bit k of `cfgMask` is 1, slot k sends all zeros and does not pop the FIFO. Unmasked slots take FIFO words in order.
- R4: `cfgFormat`=1 (left-justified): `frameSync` is high during the first `cfgSyncM1`+1 bit periods of each frame and low otherwise, including idle.
- R5: `cfgFormat`=0 (I2S): `frameSync` is low during the first `cfgSyncM1`+1 bit periods of each frame and high otherwise. `serData` lags the frame by one bit period. The first period after idle carries 0, and the frame's final bit appears on one extra tick, which has `bitClkEn` high and `frameSync` high.
- R6: `cfgFormat`=2 (right-justified): `frameSync` is high during the last `cfgSyncM1`+1 bit periods of each frame and low otherwise.
- R7: `wordStartFlag` is set at the tick on which slot `cfgFlagSlot` begins. It stays set until cleared.
- R8: When an unmasked slot begins while `fifoEmpty` is high, `fifoErrFlag` is set and stays set. That slot sends zeros and no pop occurs.
- R9: A new frame starts on a tick while `enable` is high. When `enable` is low at a frame's last bit, transmission stops there. `txActive` stays high from the first tick until that final bit's tick.
- R10: A one-cycle pulse on `clrWordStart` or `clrFifoErr` clears only the matching flag, one clock later.
- R11: Reset or `softRst` clears `txActive`, both flags, `serData`, `frameSync` and `bitClkEn`, and makes the next frame start at slot 0.
- R12: `fifoPop` is high for one clock only at the first-bit tick of an unmasked slot with data available. That slot's first bit is taken from the word present in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous engine reset (counters, flags, outputs) |
| enable | input | 1 | Transmit request; sampled at frame boundaries |
| bitTick | input | 1 | One-cycle strobe per bit period |
| cfgFormat | input | 2 | 0 I2S-style, 1 left-justified, 2 right-justified |
| cfgSlotsM1 | input | SLOT_W | Slots per frame minus one |
| cfgHeadBitsM1 | input | 5 | Slot 0 width minus one |
| cfgBitsM1 | input | 5 | Width of other slots minus one |
| cfgSyncM1 | input | 5 | Sync length in bit periods minus one (at most slot 0 width) |
| cfgMask | input | MAX_WORDS | Per-slot mute bits |
| cfgFirstBit | input | 5 | Word bit index sent first |
| cfgFlagSlot | input | SLOT_W | Slot that sets the word-start flag |
| clrWordStart | input | 1 | Clear pulse for `wordStartFlag` |
| clrFifoErr | input | 1 | Clear pulse for `fifoErrFlag` |
| fifoEmpty | input | 1 | FIFO has no word |
| fifoData | input | 32 | Current FIFO word (show-ahead) |
| fifoPop | output | 1 | Consume current FIFO word |
| serData | output | 1 | Serial data line |
| frameSync | output | 1 | Frame sync line |
| bitClkEn | output | 1 | High while presented bits are valid |
| txActive | output | 1 | Transmitter busy |
| wordStartFlag | output | 1 | Sticky slot-start flag |
| fifoErrFlag | output | 1 | Sticky underrun flag |

## Verification
Every line output changes at the clock edge that sees `bitTick`, so each tick's results are due one clock later. The bench raises the tick at a falling edge, lowers it at the next falling edge, and reads the outputs at that moment, giving one recorded sample per tick. It predicts the whole per-tick stream of data, sync, strobe, busy and flag values from the frame arithmetic, including the extra lagging tick in I2S mode. Flag clears and soft reset act without a tick and are read one clock after the pulse. FIFO consumption is judged from the bench's own read pointer after the run.

// File: rtl/audser_pkg.sv
package audser_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_SPARE = 2'd3
  } fmt_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;      // soft reset
    logic tick;       // bit period boundary
    logic emit;       // a frame bit is produced this tick
    logic wordBegin;  // first bit of a slot
    logic load;       // slot takes the FIFO word
    logic i2s;        // one-bit data lag
  } strobe_t;
endpackage

// File: rtl/audser_dp.sv
module audser_dp
  import audser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] fifoData,
  input  logic [IDX_W-1:0]  cfgFirstBit,
  output logic              serData
);
  logic [DATA_W-1:0] shiftWord;
  logic [IDX_W-1:0]  bitPtr;
  logic              lagBit;
  logic              curBit;

  always_comb begin
    if (stb.wordBegin) curBit = stb.load & fifoData[cfgFirstBit];
    else               curBit = shiftWord[bitPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
      bitPtr    <= '0;
      lagBit    <= 1'b0;
      serData   <= 1'b0;
    end else if (stb.clear) begin
      shiftWord <= '0;
      bitPtr    <= '0;
      lagBit    <= 1'b0;
      serData   <= 1'b0;
    end else if (stb.tick) begin
      lagBit  <= stb.emit & curBit;
      serData <= stb.i2s ? lagBit : (stb.emit & curBit);
      if (stb.wordBegin) begin
        shiftWord <= stb.load ? fifoData : '0;
        bitPtr    <= cfgFirstBit - IDX_W'(1);
      end else if (stb.emit) begin
        bitPtr <= bitPtr - IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/audser_ctrl.sv
module audser_ctrl
  import audser_pkg::*;
#(
  parameter  int MAX_WORDS = 8,
  localparam int SLOT_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int FBIT_W = $clog2(MAX_WORDS * DATA_W),
  localparam int SUM_W  = FBIT_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 softRst,
  input  logic                 enable,
  input  logic                 bitTick,
  input  logic [1:0]           cfgFormat,
  input  logic [SLOT_W-1:0]    cfgSlotsM1,
  input  logic [IDX_W-1:0]     cfgHeadBitsM1,
  input  logic [IDX_W-1:0]     cfgBitsM1,
  input  logic [IDX_W-1:0]     cfgSyncM1,
  input  logic [MAX_WORDS-1:0] cfgMask,
  input  logic [SLOT_W-1:0]    cfgFlagSlot,
  input  logic                 clrWordStart,
  input  logic                 clrFifoErr,
  input  logic                 fifoEmpty,
  output strobe_t              stb,
  output logic                 frameSync,
  output logic                 bitClkEn,
  output logic                 txActive,
  output logic                 wordStartFlag,
  output logic                 fifoErrFlag
);
  logic              running, tailPend;
  logic [IDX_W-1:0]  bitIdx;
  logic [SLOT_W-1:0] slotIdx;
  logic [FBIT_W-1:0] frameBit;

  logic isI2s, isRight, emit, lastBit, lastSlot, frameEnd;
  logic wordBegin, slotMuted, load, starve, syncHit;
  logic [IDX_W-1:0] curBitsM1;
  logic [SUM_W-1:0] frameBits, syncLen, tailPos;

  always_comb begin
    isI2s     = (cfgFormat == FMT_I2S);
    isRight   = (cfgFormat == FMT_RIGHT);
    curBitsM1 = (slotIdx == '0) ? cfgHeadBitsM1 : cfgBitsM1;
    lastBit   = (bitIdx == curBitsM1);
    lastSlot  = (slotIdx == cfgSlotsM1);
    emit      = bitTick & (running | enable) & ~softRst;
    frameEnd  = emit & lastBit & lastSlot;
    wordBegin = emit & (bitIdx == '0);
    slotMuted = cfgMask[slotIdx];
    load      = wordBegin & ~slotMuted & ~fifoEmpty;
    starve    = wordBegin & ~slotMuted & fifoEmpty;
    frameBits = SUM_W'(cfgHeadBitsM1) + SUM_W'(1)
              + SUM_W'(cfgSlotsM1) * (SUM_W'(cfgBitsM1) + SUM_W'(1));
    syncLen   = SUM_W'(cfgSyncM1) + SUM_W'(1);
    tailPos   = SUM_W'(frameBit) + syncLen;
    syncHit   = isRight ? (tailPos >= frameBits) : (SUM_W'(frameBit) < syncLen);
  end

  always_comb begin
    stb.clear     = softRst;
    stb.tick      = bitTick;
    stb.emit      = emit;
    stb.wordBegin = wordBegin;
    stb.load      = load;
    stb.i2s       = isI2s;
  end

  assign txActive = running;

  // frame position and line outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      tailPend  <= 1'b0;
      bitIdx    <= '0;
      slotIdx   <= '0;
      frameBit  <= '0;
      frameSync <= 1'b0;
      bitClkEn  <= 1'b0;
    end else if (softRst) begin
      running   <= 1'b0;
      tailPend  <= 1'b0;
      bitIdx    <= '0;
      slotIdx   <= '0;
      frameBit  <= '0;
      frameSync <= 1'b0;
      bitClkEn  <= 1'b0;
    end else if (bitTick) begin
      bitClkEn  <= emit | tailPend;
      tailPend  <= frameEnd & isI2s & ~enable;
      frameSync <= emit ? (isI2s ? ~syncHit : syncHit) : isI2s;
      if (emit) begin
        if (lastBit) begin
          bitIdx <= '0;
          if (lastSlot) begin
            slotIdx  <= '0;
            frameBit <= '0;
            running  <= enable;
          end else begin
            slotIdx  <= slotIdx + SLOT_W'(1);
            frameBit <= frameBit + FBIT_W'(1);
            running  <= 1'b1;
          end
        end else begin
          bitIdx   <= bitIdx + IDX_W'(1);
          frameBit <= frameBit + FBIT_W'(1);
          running  <= 1'b1;
        end
      end
    end
  end

  // sticky status, cleared by pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordStartFlag <= 1'b0;
      fifoErrFlag   <= 1'b0;
    end else if (softRst) begin
      wordStartFlag <= 1'b0;
      fifoErrFlag   <= 1'b0;
    end else begin
      wordStartFlag <= (wordStartFlag & ~clrWordStart)
                     | (wordBegin & (slotIdx == cfgFlagSlot));
      fifoErrFlag   <= (fifoErrFlag & ~clrFifoErr) | starve;
    end
  end
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import audser_pkg::*;
#(
  parameter  int MAX_WORDS = 8,
  localparam int SLOT_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 softRst,
  input  logic                 enable,
  input  logic                 bitTick,
  input  logic [1:0]           cfgFormat,
  input  logic [SLOT_W-1:0]    cfgSlotsM1,
  input  logic [4:0]           cfgHeadBitsM1,
  input  logic [4:0]           cfgBitsM1,
  input  logic [4:0]           cfgSyncM1,
  input  logic [MAX_WORDS-1:0] cfgMask,
  input  logic [4:0]           cfgFirstBit,
  input  logic [SLOT_W-1:0]    cfgFlagSlot,
  input  logic                 clrWordStart,
  input  logic                 clrFifoErr,
  input  logic                 fifoEmpty,
  input  logic [31:0]          fifoData,
  output logic                 fifoPop,
  output logic                 serData,
  output logic                 frameSync,
  output logic                 bitClkEn,
  output logic                 txActive,
  output logic                 wordStartFlag,
  output logic                 fifoErrFlag
);
  strobe_t stb;

  audser_ctrl #(.MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .enable(enable), .bitTick(bitTick),
    .cfgFormat(cfgFormat), .cfgSlotsM1(cfgSlotsM1), .cfgHeadBitsM1(cfgHeadBitsM1),
    .cfgBitsM1(cfgBitsM1), .cfgSyncM1(cfgSyncM1), .cfgMask(cfgMask),
    .cfgFlagSlot(cfgFlagSlot), .clrWordStart(clrWordStart), .clrFifoErr(clrFifoErr),
    .fifoEmpty(fifoEmpty), .stb(stb), .frameSync(frameSync), .bitClkEn(bitClkEn),
    .txActive(txActive), .wordStartFlag(wordStartFlag), .fifoErrFlag(fifoErrFlag)
  );

  audser_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fifoData(fifoData),
    .cfgFirstBit(cfgFirstBit), .serData(serData)
  );

  assign fifoPop = stb.load;
endmodule

// File: rtl/audser_chk.sv
module audser_chk (
  input logic clk,
  input logic rstN,
  input logic softRst,
  input logic bitTick,
  input logic fifoEmpty,
  input logic fifoPop,
  input logic serData,
  input logic frameSync,
  input logic bitClkEn,
  input logic txActive,
  input logic wordStartFlag,
  input logic fifoErrFlag,
  input logic clrWordStart,
  input logic clrFifoErr
);
  p_pop_with_data_r12: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (bitTick && !fifoEmpty && !softRst));

  p_lines_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !softRst) |=> ($stable(serData) && $stable(frameSync) && $stable(bitClkEn)));

  p_quiet_line_r1: assert property (@(posedge clk) disable iff (!rstN)
    !bitClkEn |-> !serData);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoErrFlag && !clrFifoErr && !softRst) |=> fifoErrFlag);

  p_start_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wordStartFlag && !clrWordStart && !softRst) |=> wordStartFlag);

  p_busy_ends_on_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txActive) |-> $past(bitTick || softRst));

  p_soft_reset_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!txActive && !bitClkEn && !serData && !frameSync
                 && !wordStartFlag && !fifoErrFlag));
endmodule

bind audio_frame_tx audser_chk u_chk (.*);

// File: tb/audio_frame_tx_bench.sv
`timescale 1ns/1ps
module audio_frame_tx_bench;
  localparam int MAX_WORDS = 8;
  localparam int SLOT_W = 3;
  localparam int REC = 512;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, softRst = 1'b0, enable = 1'b0, bitTick = 1'b0;
  logic [1:0] cfgFormat = 2'd1;
  logic [SLOT_W-1:0] cfgSlotsM1 = '0, cfgFlagSlot = '0;
  logic [4:0] cfgHeadBitsM1 = 5'd7, cfgBitsM1 = 5'd7, cfgSyncM1 = 5'd0, cfgFirstBit = 5'd31;
  logic [MAX_WORDS-1:0] cfgMask = '0;
  logic clrWordStart = 1'b0, clrFifoErr = 1'b0;
  logic fifoEmpty, fifoPop, serData, frameSync, bitClkEn, txActive, wordStartFlag, fifoErrFlag;
  logic [31:0] fifoData;

  logic [31:0] fifoMem [0:63];
  int nAvail = 64;
  int rdPtr = 0;
  logic fifoFlush = 1'b0;
  assign fifoEmpty = (rdPtr >= nAvail);
  assign fifoData  = fifoMem[rdPtr[5:0]];
  always @(posedge clk) begin
    if (fifoFlush) rdPtr <= 0;
    else if (fifoPop) rdPtr <= rdPtr + 1;
  end

  audio_frame_tx #(.MAX_WORDS(MAX_WORDS)) u_audio_frame_tx (.*);

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  logic recSd [0:REC-1];
  logic recFs [0:REC-1];
  logic recCe [0:REC-1];
  logic recTa [0:REC-1];
  logic recWs [0:REC-1];
  logic recFe [0:REC-1];
  logic expBit [0:REC-1];

  function automatic logic [31:0] wordVal(input int u);
    return 32'h6C8E_9CF5 ^ (32'(u) * 32'h9E37_79B9);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doTick();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
  endtask

  task automatic engineReset(input bit flush);
    @(negedge clk) begin softRst = 1'b1; fifoFlush = flush; end
    @(negedge clk) begin softRst = 1'b0; fifoFlush = 1'b0; end
  endtask

  task automatic runCase(input int fmt, input int slotsM1, input int headM1, input int bitsM1,
                         input int syncM1, input int mask, input int fb, input int flagSlot,
                         input int nFrames, input int avail);
    int hw, bw, total, nBits, syncLen, u, errPos, wsPos, idx, ticks, expLen;
    int badSd, badFs, badCe, badTa, badWs, badFe;
    int firstSd, firstFs, firstCe, firstTa, firstWs, firstFe;
    bit isI2s;
    string dTag, sTag;
    enable = 1'b0;
    cfgFormat = 2'(fmt); cfgSlotsM1 = SLOT_W'(slotsM1); cfgHeadBitsM1 = 5'(headM1);
    cfgBitsM1 = 5'(bitsM1); cfgSyncM1 = 5'(syncM1); cfgMask = MAX_WORDS'(mask);
    cfgFirstBit = 5'(fb); cfgFlagSlot = SLOT_W'(flagSlot);
    nAvail = avail;
    engineReset(1'b1);
    hw = headM1 + 1; bw = bitsM1 + 1; syncLen = syncM1 + 1;
    total = hw + slotsM1 * bw; nBits = total * nFrames;
    isI2s = (fmt == 0);
    u = 0; errPos = -1; idx = 0;
    for (int f = 0; f < nFrames; f++) begin
      for (int s = 0; s <= slotsM1; s++) begin
        logic [31:0] w;
        int wid;
        wid = (s == 0) ? hw : bw;
        w = '0;
        if (((mask >> s) & 1) == 0) begin
          if (u < avail) begin w = wordVal(u); u++; end
          else if (errPos < 0) errPos = idx;
        end
        for (int j = 0; j < wid; j++) begin
          expBit[idx] = w[(fb - j) & 31];
          idx++;
        end
      end
    end
    wsPos = (flagSlot > slotsM1) ? -1 : ((flagSlot == 0) ? 0 : hw + (flagSlot - 1) * bw);
    ticks = nBits + 3;
    expLen = nBits + (isI2s ? 1 : 0);
    enable = 1'b1;
    for (int i = 0; i < ticks; i++) begin
      doTick();
      recSd[i] = serData; recFs[i] = frameSync; recCe[i] = bitClkEn;
      recTa[i] = txActive; recWs[i] = wordStartFlag; recFe[i] = fifoErrFlag;
      if (i == total * (nFrames - 1)) enable = 1'b0;
    end
    badSd = 0; badFs = 0; badCe = 0; badTa = 0; badWs = 0; badFe = 0;
    firstSd = -1; firstFs = -1; firstCe = -1; firstTa = -1; firstWs = -1; firstFe = -1;
    for (int i = 0; i < ticks; i++) begin
      logic eSd, eFs, hit;
      int fp;
      if (isI2s) eSd = (i >= 1 && i <= nBits) ? expBit[i-1] : 1'b0;
      else       eSd = (i < nBits) ? expBit[i] : 1'b0;
      if (i < nBits) begin
        fp = i % total;
        hit = (fmt == 2) ? (fp >= total - syncLen) : (fp < syncLen);
        eFs = isI2s ? !hit : hit;
      end else eFs = isI2s;
      if (recSd[i] !== eSd) begin badSd++; if (firstSd < 0) firstSd = i; end
      if (recFs[i] !== eFs) begin badFs++; if (firstFs < 0) firstFs = i; end
      if (recCe[i] !== (i < expLen)) begin badCe++; if (firstCe < 0) firstCe = i; end
      if (recTa[i] !== (i < nBits - 1)) begin badTa++; if (firstTa < 0) firstTa = i; end
      if (recWs[i] !== (wsPos >= 0 && i >= wsPos)) begin badWs++; if (firstWs < 0) firstWs = i; end
      if (recFe[i] !== (errPos >= 0 && i >= errPos)) begin badFe++; if (firstFe < 0) firstFe = i; end
    end
    dTag = (errPos >= 0) ? "R8" : ((mask != 0) ? "R3" : "R2");
    sTag = isI2s ? "R5" : ((fmt == 2) ? "R6" : "R4");
    check(badCe == 0, "R1", $sformatf("bit strobe mismatches (first tick %0d)", firstCe), badCe, 0);
    check(badSd == 0, dTag, $sformatf("data mismatches fmt %0d fb %0d (first tick %0d)", fmt, fb, firstSd), badSd, 0);
    check(badFs == 0, sTag, $sformatf("sync mismatches (first tick %0d)", firstFs), badFs, 0);
    check(badTa == 0, "R9", $sformatf("busy mismatches (first tick %0d)", firstTa), badTa, 0);
    check(badWs == 0, "R7", $sformatf("word-start flag mismatches (first tick %0d)", firstWs), badWs, 0);
    check(badFe == 0, "R8", $sformatf("underrun flag mismatches (first tick %0d)", firstFe), badFe, 0);
    check(rdPtr == u, "R12", "words popped", rdPtr, u);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) fifoMem[k] = wordVal(k);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!serData && !frameSync && !bitClkEn && !txActive, "R11", "line outputs after reset",
          {serData, frameSync, bitClkEn, txActive}, 0);
    check(!wordStartFlag && !fifoErrFlag && !fifoPop, "R11", "flags and pop after reset",
          {wordStartFlag, fifoErrFlag, fifoPop}, 0);

    // sweep: formats x layouts x first-bit positions
    for (int fmt = 0; fmt < 3; fmt++) begin
      for (int fbSel = 0; fbSel < 2; fbSel++) begin
        int fb;
        fb = (fbSel == 0) ? 31 : 7;
        runCase(fmt, 1, 15, 15, 15, 'h0, fb, 1, 2, 64);
        runCase(fmt, 2, 11, 7, 0, 'h2, fb, 2, 3, 64);
        runCase(fmt, 0, 31, 7, 4, 'h0, fb, 0, 2, 64);
        runCase(fmt, 3, 8, 9, 8, 'h9, fb, 5, 3, 64);
      end
    end

    // underrun: six slots needed, three words present
    runCase(1, 1, 15, 15, 3, 'h0, 23, 0, 3, 3);
    @(negedge clk) clrFifoErr = 1'b1;
    @(negedge clk) clrFifoErr = 1'b0;
    check(!fifoErrFlag, "R10", "underrun flag after clear", fifoErrFlag, 0);
    check(wordStartFlag, "R10", "word-start flag untouched by other clear", wordStartFlag, 1);
    @(negedge clk) clrWordStart = 1'b1;
    @(negedge clk) clrWordStart = 1'b0;
    check(!wordStartFlag, "R10", "word-start flag after clear", wordStartFlag, 0);

    // soft reset in mid-frame
    cfgFormat = 2'd1; cfgSlotsM1 = 3'd1; cfgHeadBitsM1 = 5'd15; cfgBitsM1 = 5'd15;
    cfgSyncM1 = 5'd0; cfgMask = '0; cfgFirstBit = 5'd31; cfgFlagSlot = 3'd0; nAvail = 64;
    engineReset(1'b1);
    enable = 1'b1;
    repeat (5) doTick();
    engineReset(1'b0);
    check(!txActive && !bitClkEn && !serData && !frameSync, "R11", "lines after soft reset",
          {txActive, bitClkEn, serData, frameSync}, 0);
    check(!wordStartFlag && !fifoErrFlag, "R11", "flags after soft reset",
          {wordStartFlag, fifoErrFlag}, 0);
    doTick();
    check(wordStartFlag, "R11", "slot 0 begins after soft reset", wordStartFlag, 1);
    check(serData == wordVal(1)[31], "R11", "first bit after soft reset", serData, wordVal(1)[31]);
    enable = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule